// File: doc/BRIEF.md
# Level Interrupt Controller

This block gathers a wide set of level-sensitive interrupt lines, arranged in groups of 32, and presents them to a processor as one interrupt request. Each line has a mask bit. Software changes the mask only through paired registers per group. One register sets mask bits and the other clears them. In both, a bit written as 0 leaves its line alone. A per-group pending register shows which lines are active and not masked.

When an unmasked line becomes active, the controller raises `cpu_irq` and records the lines that caused it. After that point, the controller ignores newly active lines. The request stays high only while a recorded line is still active and unmasked. Software masks or services the source and then writes 1 to the control register. That write acknowledges the request and re-arms the controller, which then evaluates all lines again.

A configuration register holds an autoidle flag and a soft-reset trigger. A status register reports when the soft reset has finished. A read-only revision word identifies the block. Register reads are registered, so `bus_rdata` answers the address presented one cycle earlier.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, all mask bits are 1, `cpu_irq` is 0, the configuration register reads 0, and status bit 0 reads 1.
- R2: Offset 0x000 reads {24'b0, major[3:0], minor[3:0]}. With default parameters this is 0x00000021.
- R3: A write to the mask-set offset of group n (0x08C + n*0x20) sets mask bit k of line 32n+k for every 1 in bit k of the data. Bits written as 0 keep their value. Both the mask-set and mask-clear offsets read back the group's mask.
- R4: A write to the mask-clear offset of group n (0x088 + n*0x20) clears mask bit k for every 1 in bit k of the data. Bits written as 0 keep their value.
- R5: The pending offset of group n (0x098 + n*0x20) reads the group's line inputs AND NOT the group's mask.
- R6: When the controller is re-armed, `cpu_irq` goes to 1 at the clock edge after any unmasked line is active. Masked lines never raise it. It falls once none of the recorded lines is both active and unmasked.
- R7: Once `cpu_irq` has risen, lines that were not active at that edge cannot drive it until an acknowledge. A write to offset 0x048 with bit 0 = 1 is an acknowledge. It forces `cpu_irq` to 0 for one cycle, and the controller re-evaluates all lines at the following edge.
- R8: Writing configuration offset 0x010 with bit 1 = 1 starts a soft reset. Mask, configuration and interrupt state return to their reset values at once. Status offset 0x014 bit 0 reads 0 and configuration bit 1 reads 1 for SRST_CYCLES cycles, after which they return to 1 and 0. All writes are ignored during that time.
- R9: Configuration bit 0 (autoidle) holds the value last written and reads back.
- R10: Reads of unimplemented offsets return 0, and writes to them change no register. This includes offsets of groups beyond NUM_GROUPS and unaligned offsets.
- R11: `bus_rdata` shows the register addressed in the previous cycle and keeps that value until the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | GROUP_W | Write data |
| bus_rdata | output | GROUP_W | Registered read data for last cycle's address |
| irq_lines | input | NUM_GROUPS*GROUP_W | Level-sensitive interrupt inputs |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
Some properties are checked on every cycle. `cpu_irq` is only ever high after an unmasked line was active in the previous cycle. It cannot rise while the controller is waiting for an acknowledge. An acknowledge drops it at the next edge. A soft reset sets every mask bit and clears the done flag, and the busy window never lasts longer than SRST_CYCLES. Mask-set writes OR their data into the mask.

Other behaviour is only visible through the scenarios. These cover the values read back through the register map: revision, pending words, mask readback from both offsets, the autoidle bit, zeros from unimplemented offsets, and the read latency. They also cover the order of events in a full mask-then-acknowledge handshake with a second line queued behind the first.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Byte offsets of the register map
  localparam int OFF_REV     = 'h000;
  localparam int OFF_CFG     = 'h010;
  localparam int OFF_STAT    = 'h014;
  localparam int OFF_CTRL    = 'h048;
  localparam int OFF_MCLR    = 'h088;
  localparam int OFF_MSET    = 'h08C;
  localparam int OFF_PEND    = 'h098;
  localparam int GRP_STRIDE  = 'h020;

  // Bit positions inside configuration, status and control words
  localparam int CFG_IDLE_BIT  = 0;
  localparam int CFG_SRST_BIT  = 1;
  localparam int STAT_DONE_BIT = 0;
  localparam int CTRL_ACK_BIT  = 0;
endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
  parameter int GROUP_W = 32
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               set_we,
  input  logic               clr_we,
  input  logic [GROUP_W-1:0] wdata,
  output logic [GROUP_W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (clr)
      mask <= '1;
    else if (set_we)
      mask <= mask | wdata;
    else if (clr_we)
      mask <= mask & ~wdata;
  end
endmodule

// File: rtl/irqc_gate.sv
module irqc_gate #(
  parameter int N = 96
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ack,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] mask,
  output logic         irq,
  output logic         locked
);
  logic [N-1:0] live;
  logic [N-1:0] snap;

  assign live = lines & ~mask;

  always_ff @(posedge clk) begin
    if (clr || ack) begin
      irq    <= 1'b0;
      locked <= 1'b0;
      snap   <= '0;
    end else if (!locked) begin
      if (|live) begin
        irq    <= 1'b1;
        locked <= 1'b1;
        snap   <= live;
      end else begin
        irq    <= 1'b0;
      end
    end else begin
      snap <= snap & live;
      irq  <= |(snap & live);
    end
  end
endmodule

// File: rtl/irqc_sysctl.sv
module irqc_sysctl #(
  parameter int SRST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [1:0] cfg_wdata,
  output logic       soft_go,
  output logic       busy,
  output logic       autoidle,
  output logic       done
);
  localparam int CNT_W = $clog2(SRST_CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  assign soft_go = cfg_we && cfg_wdata[irqc_pkg::CFG_SRST_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      autoidle <= 1'b0;
      done     <= 1'b1;
    end else if (soft_go) begin
      busy     <= 1'b1;
      cnt      <= CNT_W'(SRST_CYCLES - 1);
      autoidle <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (cfg_we)
        autoidle <= cfg_wdata[irqc_pkg::CFG_IDLE_BIT];
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int NUM_GROUPS  = 3,
  parameter int GROUP_W     = 32,
  parameter int ADDR_W      = 12,
  parameter int REV_MAJOR   = 2,
  parameter int REV_MINOR   = 1,
  parameter int SRST_CYCLES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic [GROUP_W-1:0]            bus_wdata,
  output logic [GROUP_W-1:0]            bus_rdata,
  input  logic [NUM_GROUPS*GROUP_W-1:0] irq_lines,
  output logic                          cpu_irq
);
  import irqc_pkg::*;

  localparam int NUM_LINES = NUM_GROUPS * GROUP_W;
  localparam logic [GROUP_W-1:0] REV_WORD =
    {{(GROUP_W-8){1'b0}}, 4'(REV_MAJOR), 4'(REV_MINOR)};

  logic                 busy, autoidle, done, soft_go, wr_ok, ack, clr_all;
  logic                 gate_locked;
  logic [NUM_LINES-1:0] mask_flat;
  logic [NUM_LINES-1:0] pend_flat;
  logic [GROUP_W-1:0]   rd_next;

  assign wr_ok   = bus_wr && !busy;
  assign ack     = wr_ok && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[CTRL_ACK_BIT];
  assign clr_all = rst || soft_go;

  irqc_sysctl #(.SRST_CYCLES(SRST_CYCLES)) i_sysctl (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (wr_ok && (bus_addr == ADDR_W'(OFF_CFG))),
    .cfg_wdata (bus_wdata[1:0]),
    .soft_go   (soft_go),
    .busy      (busy),
    .autoidle  (autoidle),
    .done      (done)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
    irqc_mask_bank #(.GROUP_W(GROUP_W)) i_bank (
      .clk    (clk),
      .clr    (clr_all),
      .set_we (wr_ok && (bus_addr == ADDR_W'(OFF_MSET + g*GRP_STRIDE))),
      .clr_we (wr_ok && (bus_addr == ADDR_W'(OFF_MCLR + g*GRP_STRIDE))),
      .wdata  (bus_wdata),
      .mask   (mask_flat[g*GROUP_W +: GROUP_W])
    );
  end

  irqc_gate #(.N(NUM_LINES)) i_gate (
    .clk    (clk),
    .clr    (clr_all),
    .ack    (ack),
    .lines  (irq_lines),
    .mask   (mask_flat),
    .irq    (cpu_irq),
    .locked (gate_locked)
  );

  assign pend_flat = irq_lines & ~mask_flat;

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(OFF_REV))
      rd_next = REV_WORD;
    else if (bus_addr == ADDR_W'(OFF_CFG)) begin
      rd_next[CFG_IDLE_BIT] = autoidle;
      rd_next[CFG_SRST_BIT] = busy;
    end else if (bus_addr == ADDR_W'(OFF_STAT))
      rd_next[STAT_DONE_BIT] = done;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (bus_addr == ADDR_W'(OFF_MCLR + g*GRP_STRIDE) ||
          bus_addr == ADDR_W'(OFF_MSET + g*GRP_STRIDE))
        rd_next = mask_flat[g*GROUP_W +: GROUP_W];
      if (bus_addr == ADDR_W'(OFF_PEND + g*GRP_STRIDE))
        rd_next = pend_flat[g*GROUP_W +: GROUP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else
      bus_rdata <= rd_next;
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_LINES   = 96,
  parameter int GROUP_W     = 32,
  parameter int ADDR_W      = 12,
  parameter int SRST_CYCLES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [GROUP_W-1:0]   bus_wdata,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic [NUM_LINES-1:0] mask_flat,
  input logic                 cpu_irq,
  input logic                 locked,
  input logic                 busy,
  input logic                 done,
  input logic                 soft_go
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (rst || !busy)
      busy_run <= 0;
    else
      busy_run <= busy_run + 1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mask_flat && !cpu_irq && done));

  assert_mask_set_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !busy && bus_addr == ADDR_W'(irqc_pkg::OFF_MSET))
      |=> (mask_flat[GROUP_W-1:0] == ($past(mask_flat[GROUP_W-1:0]) | $past(bus_wdata))));

  assert_irq_has_source_R6: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> $past(|(irq_lines & ~mask_flat)));

  assert_no_rise_locked_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_irq) |-> !$past(locked));

  assert_ack_drops_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !busy && bus_addr == ADDR_W'(irqc_pkg::OFF_CTRL) && bus_wdata[0])
      |=> (!cpu_irq && !locked));

  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (rst)
    soft_go |=> (&mask_flat && busy && !done && !cpu_irq));

  assert_busy_bound_R8: assert property (@(posedge clk) disable iff (rst)
    busy_run <= SRST_CYCLES);
endmodule

bind lvl_irq_ctrl irqc_checker #(
  .NUM_LINES   (NUM_LINES),
  .GROUP_W     (GROUP_W),
  .ADDR_W      (ADDR_W),
  .SRST_CYCLES (SRST_CYCLES)
) i_irqc_checker (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_lines (irq_lines),
  .mask_flat (mask_flat),
  .cpu_irq   (cpu_irq),
  .locked    (gate_locked),
  .busy      (busy),
  .done      (done),
  .soft_go   (soft_go)
);

// File: tb/test_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module test_lvl_irq_ctrl;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_REV = 12'h000, A_CFG = 12'h010, A_STAT = 12'h014,
                            A_CTRL = 12'h048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [95:0] irq_lines = '0;
  logic        cpu_irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lvl_irq_ctrl i_lvl_irq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .cpu_irq(cpu_irq)
  );

  function automatic logic [AW-1:0] a_clr(int g); return AW'(12'h088 + g*12'h20); endfunction
  function automatic logic [AW-1:0] a_set(int g); return AW'(12'h08C + g*12'h20); endfunction
  function automatic logic [AW-1:0] a_pnd(int g); return AW'(12'h098 + g*12'h20); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All tasks are entered and left at a falling edge
  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset_state;
    logic [31:0] v;
    check("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);
    for (int g = 0; g < 3; g++) begin
      rd(a_set(g), v); check("R1 mask", v, 32'hFFFF_FFFF);
    end
    rd(A_CFG, v);  check("R1 cfg", v, 32'h0);
    rd(A_STAT, v); check("R1 status", v, 32'h1);
    rd(A_REV, v);  check("R2 revision", v, 32'h0000_0021);
  endtask

  task automatic t_read_latency;
    logic [31:0] v;
    rd(A_REV, v);
    bus_addr = A_STAT;
    #1 check("R11 rdata holds until edge", bus_rdata, 32'h0000_0021);
    @(negedge clk);
    check("R11 rdata after edge", bus_rdata, 32'h1);
  endtask

  task automatic t_mask_ops;
    logic [31:0] v;
    wr(a_clr(1), 32'h0000_F0F0);
    rd(a_clr(1), v); check("R4 clear readback", v, 32'hFFFF_0F0F);
    rd(a_set(1), v); check("R3 set offset readback", v, 32'hFFFF_0F0F);
    wr(a_set(1), 32'h0000_0010);
    rd(a_set(1), v); check("R3 set bit", v, 32'hFFFF_0F1F);
    wr(a_set(1), 32'h0);
    rd(a_set(1), v); check("R3 zero write", v, 32'hFFFF_0F1F);
    wr(a_clr(1), 32'h0);
    rd(a_set(1), v); check("R4 zero write", v, 32'hFFFF_0F1F);
  endtask

  task automatic t_pending;
    logic [31:0] v;
    irq_lines = {32'hAAAA_0000, 32'h0000_FFFF, 32'h1234_5678};
    wr(a_clr(0), 32'hFFFF_0000);
    rd(a_pnd(0), v); check("R5 pending g0", v, 32'h1234_0000);
    rd(a_pnd(1), v); check("R5 pending g1", v, 32'h0000_F0E0);
    rd(a_pnd(2), v); check("R5 pending g2", v, 32'h0);
    irq_lines = '0;
    wr(a_set(0), 32'hFFFF_FFFF);
    wr(a_set(1), 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1);
    @(negedge clk);
    check("R7 idle after ack", {31'b0, cpu_irq}, 32'h0);
  endtask

  task automatic t_handshake;
    irq_lines[6] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R6 masked line silent", {31'b0, cpu_irq}, 32'h0);
    irq_lines[6] = 1'b0;
    wr(a_clr(0), 32'h0000_0020);
    wr(a_clr(1), 32'h0000_0100);
    irq_lines[5] = 1'b1;
    @(negedge clk);
    check("R6 raise", {31'b0, cpu_irq}, 32'h1);
    irq_lines[40] = 1'b1;
    @(negedge clk);
    check("R6 held", {31'b0, cpu_irq}, 32'h1);
    wr(a_set(0), 32'h0000_0020);
    @(negedge clk);
    check("R7 new line blocked while locked", {31'b0, cpu_irq}, 32'h0);
    wr(A_CTRL, 32'h1);
    check("R7 low after ack", {31'b0, cpu_irq}, 32'h0);
    @(negedge clk);
    check("R7 re-evaluate after ack", {31'b0, cpu_irq}, 32'h1);
    irq_lines[40] = 1'b0;
    @(negedge clk);
    check("R6 level drop", {31'b0, cpu_irq}, 32'h0);
    wr(A_CTRL, 32'h1);
    wr(a_set(1), 32'h0000_0100);
    irq_lines = '0;
  endtask

  task automatic t_soft_reset;
    logic [31:0] v;
    int n;
    wr(A_CFG, 32'h1);
    rd(A_CFG, v); check("R9 autoidle set", v, 32'h1);
    wr(A_CFG, 32'h0);
    rd(A_CFG, v); check("R9 autoidle clear", v, 32'h0);
    wr(A_CFG, 32'h1);
    wr(a_clr(2), 32'h0000_FFFF);
    rd(a_set(2), v); check("R4 group2 clear", v, 32'hFFFF_0000);
    wr(A_CFG, 32'h2);
    rd(A_STAT, v); check("R8 done low", v, 32'h0);
    rd(A_CFG, v);  check("R8 busy bit", v, 32'h2);
    wr(a_clr(0), 32'hFFFF_FFFF);
    n = 0;
    v = 32'h0;
    while (v != 32'h1 && n < 20) begin
      rd(A_STAT, v);
      n++;
    end
    check("R8 done returns", v, 32'h1);
    rd(A_CFG, v);    check("R8 cfg cleared", v, 32'h0);
    rd(a_set(2), v); check("R8 mask restored", v, 32'hFFFF_FFFF);
    rd(a_set(0), v); check("R8 write ignored while busy", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(12'h004, v); check("R10 read 0x004", v, 32'h0);
    rd(12'h0EC, v); check("R10 read group3", v, 32'h0);
    rd(12'h089, v); check("R10 read unaligned", v, 32'h0);
    wr(12'h0E8, 32'hFFFF_FFFF);
    wr(12'h089, 32'hFFFF_FFFF);
    wr(12'h080, 32'hFFFF_FFFF);
    for (int g = 0; g < 3; g++) begin
      rd(a_set(g), v); check("R10 masks untouched", v, 32'hFFFF_FFFF);
    end
    rd(A_CFG, v); check("R10 cfg untouched", v, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_read_latency();
    t_mask_ops();
    t_pending();
    t_handshake();
    t_soft_reset();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule